// File: doc/BRIEF.md
# Byte-Serial Frame Check Sequence Generator

This block accumulates the 32-bit cyclic redundancy check used by Ethernet over a stream of bytes, consuming one byte on every clock in which the input strobe is high. The register works in the bit-reversed (least-significant-bit first) orientation, so the generator is applied as the constant 0xEDB88320, which is the bit reversal of 0x04C11DB7. For each byte, eight single-bit feedback steps are flattened into a single combinational network, so a byte never takes more than one cycle.

A message begins with a clear pulse, which loads the all-ones preset. The data bytes follow, each one marked by the byte strobe. Once the final byte has been taken, the finished checksum can be read on the next cycle: it is the running register with every bit inverted. Both values leave the block, the raw running state and the inverted checksum.

Top module: `crcEngine`

## Requirements
- R1: While synchronous reset `rst` is high, the register is loaded with 0xFFFFFFFF. In the cycle after reset is released, `crcState` reads 0xFFFFFFFF and `crcOut` reads 0x00000000.
- R2: On a clock edge where `byteValid` is high, the new register value is found in two parts. First, `dataIn` is XORed into bits 7:0 of the register. Then eight rounds are applied, and in each round the value shifts right by one and is XORed with 0xEDB88320 whenever the bit shifted out was 1.
- R3: On an edge where `byteValid` and `start` are both low, the register keeps its value.
- R4: On an edge where `start` is high and `byteValid` is low, the register loads 0xFFFFFFFF.
- R5: On an edge where `start` and `byteValid` are both high, the byte is processed as described in R2, but starting from 0xFFFFFFFF instead of the old register value.
- R6: `crcOut` is always `crcState` XOR 0xFFFFFFFF. It is combinational, so it is valid in the cycle after the last byte is accepted.
- R7: Clearing the register and then feeding the ASCII bytes 0x31 through 0x39 produces `crcOut` = 0xCBF43926.
- R8: The update is linear: feeding a byte of 0x00 starting from state 0x00000000 leaves the state at 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Clear pulse that presets the register |
| byteValid | input | 1 | Byte strobe for `dataIn` |
| dataIn | input | 8 | Data byte |
| crcState | output | 32 | Raw running register |
| crcOut | output | 32 | Inverted, finished checksum |

## Verification
Assertions check on every cycle the behaviours that depend only on the current and previous cycle: the register holds while idle, loads the preset after reset or a clear without data, and keeps the output inversion exact. The arithmetic result for each byte, the case where a clear and a byte arrive together, and the standard nine-byte check value can only be shown by the bench. It compares random byte streams against a bit-serial reference model written independently of the design.

// File: rtl/crcPkg.sv
package crcPkg;
  localparam int unsigned CrcWidth  = 32;
  localparam int unsigned ByteWidth = 8;
  localparam logic [CrcWidth-1:0] PolyRefl = 32'hEDB88320;
  localparam logic [CrcWidth-1:0] PresetVal = 32'hFFFFFFFF;
  localparam logic [CrcWidth-1:0] XorOutVal = 32'hFFFFFFFF;

  typedef struct packed {
    logic load;    // take next state into register
    logic usePre;  // base the update on the preset value
    logic doByte;  // apply byte update (else pass base through)
  } crcCtl_t;
endpackage

// File: rtl/crcCtrl.sv
module crcCtrl
  import crcPkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    start,
  input  logic    byteValid,
  output crcCtl_t ctl
);
  always_comb begin
    ctl.load   = rst | start | byteValid;
    ctl.usePre = rst | start;
    ctl.doByte = byteValid & ~rst;
  end

  // R3: no load strobe when both start and valid are low (outside reset)
  a_r3_idle_no_load: assert property (@(posedge clk) disable iff (rst)
    (!start && !byteValid) |-> !ctl.load);
endmodule

// File: rtl/crcDatapath.sv
module crcDatapath
  import crcPkg::*;
#(
  parameter int unsigned Width = CrcWidth,
  parameter int unsigned DataW = ByteWidth,
  parameter logic [Width-1:0] Poly = PolyRefl,
  parameter logic [Width-1:0] Preset = PresetVal,
  parameter logic [Width-1:0] XorOut = XorOutVal
)(
  input  logic             clk,
  input  logic             rst,
  input  crcCtl_t          ctl,
  input  logic [DataW-1:0] dataIn,
  output logic [Width-1:0] state,
  output logic [Width-1:0] finalOut
);
  logic [Width-1:0] base;
  logic [Width-1:0] stage [DataW+1];
  logic [Width-1:0] nextState;

  assign base = ctl.usePre ? Preset : state;

  // R2: fold byte into low bits, then unroll one shift round per data bit
  assign stage[0] = base ^ {{(Width-DataW){1'b0}}, dataIn};
  for (genvar i = 0; i < DataW; i++) begin : g_round
    assign stage[i+1] = (stage[i] >> 1) ^ (stage[i][0] ? Poly : '0);
  end

  assign nextState = ctl.doByte ? stage[DataW] : base;

  always_ff @(posedge clk) begin
    if (ctl.load) state <= nextState;
  end

  assign finalOut = state ^ XorOut;

  // R1: preset after reset
  a_r1_reset_preset: assert property (@(posedge clk)
    rst |=> (state == Preset));
  // R4: clear without data loads preset
  a_r4_clear_preset: assert property (@(posedge clk) disable iff (rst)
    (ctl.usePre && !ctl.doByte) |=> (state == Preset));
  // R3: hold when no strobe
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.load |=> $stable(state));
  // R6: output inversion relation
  a_r6_inversion: assert property (@(posedge clk) disable iff (rst)
    (finalOut ^ state) == XorOut);
endmodule

// File: rtl/crcEngine.sv
module crcEngine
  import crcPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        byteValid,
  input  logic [7:0]  dataIn,
  output logic [31:0] crcState,
  output logic [31:0] crcOut
);
  crcCtl_t ctl;

  crcCtrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .byteValid(byteValid), .ctl(ctl)
  );

  crcDatapath u_dp (
    .clk(clk), .rst(rst), .ctl(ctl), .dataIn(dataIn),
    .state(crcState), .finalOut(crcOut)
  );

  // R8: zero byte from zero state stays zero (linearity of the update)
  a_r8_zero_linear: assert property (@(posedge clk) disable iff (rst)
    (byteValid && !start && crcState == 32'h0 && dataIn == 8'h00)
      |=> (crcState == 32'h0));
endmodule

// File: tb/crcEngine_tb.sv
module crcEngine_tb;
  logic clk = 1'b0;
  logic rst, start, byteValid;
  logic [7:0] dataIn;
  logic [31:0] crcState, crcOut;
  int checks = 0;
  int errors = 0;
  logic [31:0] model;

  always #2 clk = ~clk;

  crcEngine u_dut (
    .clk(clk), .rst(rst), .start(start), .byteValid(byteValid),
    .dataIn(dataIn), .crcState(crcState), .crcOut(crcOut)
  );

  function automatic logic [31:0] refByte(input logic [31:0] s, input logic [7:0] d);
    logic [31:0] r;
    r = s;
    for (int b = 0; b < 8; b++) begin
      logic fb;
      fb = r[0] ^ d[b];
      r = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic v, input logic [7:0] d);
    start = s; byteValid = v; dataIn = d;
    @(posedge clk); #1;
    if (s) model = 32'hFFFFFFFF;
    if (v) model = refByte(model, d);
    start = 0; byteValid = 0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual hung expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = 1234;
    void'($urandom(seed));
    rst = 1; start = 0; byteValid = 0; dataIn = 0;
    @(posedge clk); @(posedge clk); #1;
    rst = 0; model = 32'hFFFFFFFF;
    chk("R1 state", crcState, 32'hFFFFFFFF);
    chk("R1 out", crcOut, 32'h0);

    // R7 standard vector
    step(1, 0, 0);
    for (int i = 0; i < 9; i++) step(0, 1, 8'h31 + 8'(i));
    chk("R7 check value", crcOut, 32'hCBF43926);
    chk("R6 inversion", crcOut, ~crcState);

    // R3 hold
    step(0, 0, 8'hA5);
    step(0, 0, 8'h5A);
    chk("R3 hold", crcState, model);
    chk("R3 hold value", crcOut, 32'hCBF43926);

    // R4 clear alone
    step(1, 0, 8'h77);
    chk("R4 clear", crcState, 32'hFFFFFFFF);

    // R5 start with valid from dirty state
    step(0, 1, 8'h3C);
    step(1, 1, 8'h31);
    chk("R5 start+valid", crcState, refByte(32'hFFFFFFFF, 8'h31));

    // R8 drive state to zero: from preset, bytes FF x4 yield zero state
    step(1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 1, 8'hFF);
    chk("R8 zero reached", crcState, model);
    if (model == 32'h0) begin
      step(0, 1, 8'h00);
      chk("R8 zero stays", crcState, 32'h0);
    end

    // R2 random streams
    for (int m = 0; m < 40; m++) begin
      int len;
      len = 1 + int'($urandom % 20);
      step(1, ($urandom % 2) == 1, 8'($urandom));
      for (int k = 0; k < len; k++)
        step(0, ($urandom % 4) != 0, 8'($urandom));
      chk("R2 random stream", crcState, model);
      chk("R6 random out", crcOut, model ^ 32'hFFFFFFFF);
    end

    // reset mid-message
    step(0, 1, 8'h12);
    rst = 1; @(posedge clk); #1; rst = 0; model = 32'hFFFFFFFF;
    chk("R1 midstream reset", crcState, 32'hFFFFFFFF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule